// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Array

This block holds a small pool of reservation stations together with a per-register status table and the architectural register file. It accepts at most one decoded operation per cycle, in program order. For each of the two sources, the operation either picks up the register value or, when an earlier operation still owes that register a result, records the station tag of that producer. The issuing station then becomes the newest owner of its destination register. Because the table holds only the newest owner, a later writer never waits for an earlier reader or writer.

Results come back on a broadcast result bus as a value plus the tag of the station that produced it. Every station waiting on that tag loads the value. The register file accepts the value only if the status entry for that register still names the same tag. Once a station holds both operands it is offered to the execution side, the lowest-indexed ready station first. The station stays allocated until its own result is broadcast. A read port lets the owning pipeline look up any register's value and pending state.

Top module: `rs_rename_core`

## Requirements
- R1: After reset every station is free, `issue_ready` is 1, `disp_valid` is 0, and every register reads value 0 with `peek_pending` 0.
- R2: An issue takes the free station with the lowest index and reports that index on `issue_tag` (station i has tag i). When every station is allocated, `issue_ready` is 0 and an asserted `issue_valid` changes nothing.
- R3: A source register with no pending producer gives the station its current register value, and that operand counts as present.
- R4: A source register whose status names a producer gives the station that producer's tag, and the operand stays missing until that tag is broadcast.
- R5: When `bcast_valid` is high, every allocated station waiting on `bcast_tag` in either operand loads `bcast_value` into that operand. Both operands can be filled by one broadcast.
- R6: A station is offered on `disp_valid` only when both operands are present and it has not yet been dispatched. The dispatch outputs carry its tag, operation code, both operand values and its immediate field.
- R7: Among the offered stations, the lowest-indexed one drives the dispatch outputs. It is taken when `disp_ready` is 1 and is not offered again. While `disp_ready` is 0 it remains offered.
- R8: A station is freed in the cycle its own tag is broadcast. It can be allocated again from the next cycle on.
- R9: A broadcast writes a register only if that register's status still names the broadcast tag, and it then clears the pending state. A result whose destination has since been claimed by a newer issue leaves the register value unchanged.
- R10: An issue replaces the destination's status with its own tag. Later readers of that register wait on the new tag, while stations issued earlier keep the tag they already recorded.
- R11: If a source's pending producer broadcasts in the same cycle the operation issues, the new station takes the broadcast value directly and does not wait.
- R12: If an issue claims a register in the same cycle that a broadcast retires that register's previous producer, the register value is written and the status names the new issuing tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is presented for issue |
| issue_op | input | OP_W | Operation code |
| issue_src_a | input | log2(NUM_REGS) | First source register |
| issue_src_b | input | log2(NUM_REGS) | Second source register |
| issue_dst | input | log2(NUM_REGS) | Destination register |
| issue_imm | input | IMM_W | Immediate or address field carried with the operation |
| issue_ready | output | 1 | A station is free; issue is accepted this cycle |
| issue_tag | output | log2(NUM_RS) | Station that an issue this cycle would take |
| bcast_valid | input | 1 | Result bus carries a result |
| bcast_tag | input | log2(NUM_RS) | Tag of the producing station |
| bcast_value | input | DATA_W | Result value |
| disp_ready | input | 1 | Execution side accepts the offered station |
| disp_valid | output | 1 | A station with both operands is offered |
| disp_tag | output | log2(NUM_RS) | Tag of the offered station |
| disp_op | output | OP_W | Operation code of the offered station |
| disp_vj | output | DATA_W | First operand value |
| disp_vk | output | DATA_W | Second operand value |
| disp_imm | output | IMM_W | Immediate field of the offered station |
| peek_reg | input | log2(NUM_REGS) | Register to look up |
| peek_value | output | DATA_W | Architectural value of that register |
| peek_pending | output | 1 | A producer is still outstanding for that register |
| peek_tag | output | log2(NUM_RS) | Tag of that producer when pending |

## Verification
The bench replays a program with a renamed destination, so the older result comes back after its register has already been claimed again. A design that ignores the status check would overwrite the register with the stale value. One case issues an operation in the same cycle its source producer broadcasts. A design without forwarding would leave that station waiting for a tag that never returns. Another case issues a new claim on a register in the same cycle its old producer retires, and a design that lets the retire win would drop the new owner. The bench also fills every station and shows an extra issue has no effect, holds a ready station under back-pressure, and checks that a freed tag comes back as the lowest free slot.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   // Life cycle of one station entry
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,   // free for allocation
      RS_HELD = 2'd1,   // allocated, not yet dispatched
      RS_EXEC = 2'd2    // dispatched, waiting for its own broadcast
   } rs_phase_e;

   // Number of source operands per station
   localparam int OPND_N = 2;

endpackage

// File: rtl/rsv_pick.sv
// Lowest-index-first selector
module rsv_pick #(
   parameter int W    = 4,
   parameter int IDXW = 2
) (
   input  logic [W-1:0]    req,
   output logic [W-1:0]    gnt,
   output logic [IDXW-1:0] idx,
   output logic            any
);

   if (W < 2) begin : g_bad_w
      $error("rsv_pick: W must be at least 2");
   end
   if (IDXW != $clog2(W)) begin : g_bad_idx
      $error("rsv_pick: IDXW must equal clog2(W)");
   end

   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IDXW'(i);
            any    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rsv_operand.sv
// One source operand field: value plus waiting tag, with issue-time forwarding
module rsv_operand #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              src_pend,
   input  logic [TAG_W-1:0]  src_tag,
   input  logic [DATA_W-1:0] src_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              pend,
   output logic [DATA_W-1:0] val
);

   logic              pend_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              hit_src;
   logic              hit_wait;

   assign hit_src  = src_pend && bc_valid && (bc_tag == src_tag);
   assign hit_wait = pend_q && bc_valid && (bc_tag == tag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tag_q  <= '0;
         val_q  <= '0;
      end else if (load) begin
         pend_q <= src_pend && !hit_src;
         tag_q  <= src_tag;
         if (!src_pend)
            val_q <= src_val;
         else if (hit_src)
            val_q <= bc_val;
         else
            val_q <= '0;
      end else if (hit_wait) begin
         pend_q <= 1'b0;
         val_q  <= bc_val;
      end
   end

   assign pend = pend_q;
   assign val  = val_q;

endmodule

// File: rtl/rsv_slot.sv
// One reservation station entry
module rsv_slot
   import rsv_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int OP_W    = 4,
   parameter int IMM_W   = 8,
   parameter int TAG_W   = 2,
   parameter int SLOT_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [OP_W-1:0]   a_op,
   input  logic [IMM_W-1:0]  a_imm,
   input  logic              a_pend [OPND_N],
   input  logic [TAG_W-1:0]  a_tag  [OPND_N],
   input  logic [DATA_W-1:0] a_val  [OPND_N],
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   input  logic              grant,
   output logic              busy,
   output logic              ready,
   output logic [OP_W-1:0]   o_op,
   output logic [IMM_W-1:0]  o_imm,
   output logic [DATA_W-1:0] o_vj,
   output logic [DATA_W-1:0] o_vk
);

   localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(SLOT_ID);

   rs_phase_e         phase_q;
   logic [OP_W-1:0]   op_q;
   logic [IMM_W-1:0]  imm_q;
   logic              pend_w [OPND_N];
   logic [DATA_W-1:0] val_w  [OPND_N];
   logic              own_bc;

   for (genvar o = 0; o < OPND_N; o++) begin : g_opnd
      rsv_operand #(
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W)
      ) u_opnd (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (alloc),
         .src_pend (a_pend[o]),
         .src_tag  (a_tag[o]),
         .src_val  (a_val[o]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_val   (bc_val),
         .pend     (pend_w[o]),
         .val      (val_w[o])
      );
   end

   assign own_bc = bc_valid && (bc_tag == MY_TAG) && (phase_q != RS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= RS_IDLE;
         op_q    <= '0;
         imm_q   <= '0;
      end else if (alloc) begin
         phase_q <= RS_HELD;
         op_q    <= a_op;
         imm_q   <= a_imm;
      end else if (own_bc) begin
         phase_q <= RS_IDLE;
      end else if (grant) begin
         phase_q <= RS_EXEC;
      end
   end

   assign busy  = (phase_q != RS_IDLE);
   assign ready = (phase_q == RS_HELD) && !pend_w[0] && !pend_w[1];
   assign o_op  = op_q;
   assign o_imm = imm_q;
   assign o_vj  = val_w[0];
   assign o_vk  = val_w[1];

endmodule

// File: rtl/rsv_regstat.sv
// Register file with per-register newest-producer status
module rsv_regstat #(
   parameter int NUM_REGS = 8,
   parameter int REG_AW   = 3,
   parameter int DATA_W   = 16,
   parameter int TAG_W    = 2,
   parameter int NRD      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] rd_addr [NRD],
   output logic [DATA_W-1:0] rd_val  [NRD],
   output logic              rd_pend [NRD],
   output logic [TAG_W-1:0]  rd_tag  [NRD],
   input  logic              claim,
   input  logic [REG_AW-1:0] claim_reg,
   input  logic [TAG_W-1:0]  claim_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val
);

   if (NUM_REGS != (1 << REG_AW)) begin : g_bad_regs
      $error("rsv_regstat: NUM_REGS must equal 2**REG_AW");
   end

   logic [DATA_W-1:0] reg_val  [NUM_REGS];
   logic              reg_pend [NUM_REGS];
   logic [TAG_W-1:0]  reg_tag  [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [DATA_W-1:0] val_q;
      logic              pend_q;
      logic [TAG_W-1:0]  tag_q;
      logic              retire;
      logic              claim_here;

      assign retire     = bc_valid && pend_q && (tag_q == bc_tag);
      assign claim_here = claim && (claim_reg == REG_AW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            pend_q <= 1'b0;
            tag_q  <= '0;
         end else begin
            if (retire) begin
               val_q  <= bc_val;
               pend_q <= 1'b0;
            end
            if (claim_here) begin
               pend_q <= 1'b1;
               tag_q  <= claim_tag;
            end
         end
      end

      assign reg_val[r]  = val_q;
      assign reg_pend[r] = pend_q;
      assign reg_tag[r]  = tag_q;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_val[p]  = reg_val[rd_addr[p]];
      assign rd_pend[p] = reg_pend[rd_addr[p]];
      assign rd_tag[p]  = reg_tag[rd_addr[p]];
   end

endmodule

// File: rtl/rs_rename_core.sv
// Reservation station pool with tag renaming and result-bus snooping
module rs_rename_core
   import rsv_pkg::*;
#(
   parameter int NUM_RS   = 4,
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   parameter int OP_W     = 4,
   parameter int IMM_W    = 8,
   localparam int TAG_W   = $clog2(NUM_RS),
   localparam int REG_AW  = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [OP_W-1:0]   issue_op,
   input  logic [REG_AW-1:0] issue_src_a,
   input  logic [REG_AW-1:0] issue_src_b,
   input  logic [REG_AW-1:0] issue_dst,
   input  logic [IMM_W-1:0]  issue_imm,
   output logic              issue_ready,
   output logic [TAG_W-1:0]  issue_tag,
   input  logic              bcast_valid,
   input  logic [TAG_W-1:0]  bcast_tag,
   input  logic [DATA_W-1:0] bcast_value,
   input  logic              disp_ready,
   output logic              disp_valid,
   output logic [TAG_W-1:0]  disp_tag,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_vj,
   output logic [DATA_W-1:0] disp_vk,
   output logic [IMM_W-1:0]  disp_imm,
   input  logic [REG_AW-1:0] peek_reg,
   output logic [DATA_W-1:0] peek_value,
   output logic              peek_pending,
   output logic [TAG_W-1:0]  peek_tag
);

   localparam int NRD = OPND_N + 1;

   if (NUM_RS < 2) begin : g_bad_rs
      $error("rs_rename_core: NUM_RS must be at least 2");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("rs_rename_core: NUM_REGS must be at least 2");
   end
   if (DATA_W < 1 || OP_W < 1 || IMM_W < 1) begin : g_bad_w
      $error("rs_rename_core: field widths must be positive");
   end

   // station state vectors
   logic [NUM_RS-1:0] slot_busy;
   logic [NUM_RS-1:0] slot_ready;
   logic [NUM_RS-1:0] slot_grant;
   logic [NUM_RS-1:0] slot_alloc;
   logic [OP_W-1:0]   s_op  [NUM_RS];
   logic [IMM_W-1:0]  s_imm [NUM_RS];
   logic [DATA_W-1:0] s_vj  [NUM_RS];
   logic [DATA_W-1:0] s_vk  [NUM_RS];

   // selectors
   logic [NUM_RS-1:0] free_gnt;
   logic [TAG_W-1:0]  free_idx;
   logic              free_any;
   logic [NUM_RS-1:0] rdy_gnt;
   logic [TAG_W-1:0]  rdy_idx;
   logic              rdy_any;
   logic              issue_fire;

   // register table read ports: two sources, one lookup
   logic [REG_AW-1:0] rd_addr [NRD];
   logic [DATA_W-1:0] rd_val  [NRD];
   logic              rd_pend [NRD];
   logic [TAG_W-1:0]  rd_tag  [NRD];
   logic              op_pend [OPND_N];
   logic [TAG_W-1:0]  op_tag  [OPND_N];
   logic [DATA_W-1:0] op_val  [OPND_N];

   rsv_pick #(.W(NUM_RS), .IDXW(TAG_W)) u_free_pick (
      .req (~slot_busy),
      .gnt (free_gnt),
      .idx (free_idx),
      .any (free_any)
   );

   rsv_pick #(.W(NUM_RS), .IDXW(TAG_W)) u_rdy_pick (
      .req (slot_ready),
      .gnt (rdy_gnt),
      .idx (rdy_idx),
      .any (rdy_any)
   );

   assign issue_ready = free_any;
   assign issue_tag   = free_idx;
   assign issue_fire  = issue_valid && free_any;
   assign slot_alloc  = free_gnt & {NUM_RS{issue_fire}};
   assign slot_grant  = rdy_gnt & {NUM_RS{disp_ready}};

   assign rd_addr[0] = issue_src_a;
   assign rd_addr[1] = issue_src_b;
   assign rd_addr[2] = peek_reg;

   for (genvar o = 0; o < OPND_N; o++) begin : g_src
      assign op_pend[o] = rd_pend[o];
      assign op_tag[o]  = rd_tag[o];
      assign op_val[o]  = rd_val[o];
   end

   rsv_regstat #(
      .NUM_REGS (NUM_REGS),
      .REG_AW   (REG_AW),
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W),
      .NRD      (NRD)
   ) u_regstat (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (rd_addr),
      .rd_val    (rd_val),
      .rd_pend   (rd_pend),
      .rd_tag    (rd_tag),
      .claim     (issue_fire),
      .claim_reg (issue_dst),
      .claim_tag (free_idx),
      .bc_valid  (bcast_valid),
      .bc_tag    (bcast_tag),
      .bc_val    (bcast_value)
   );

   for (genvar s = 0; s < NUM_RS; s++) begin : g_slot
      rsv_slot #(
         .DATA_W  (DATA_W),
         .OP_W    (OP_W),
         .IMM_W   (IMM_W),
         .TAG_W   (TAG_W),
         .SLOT_ID (s)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (slot_alloc[s]),
         .a_op     (issue_op),
         .a_imm    (issue_imm),
         .a_pend   (op_pend),
         .a_tag    (op_tag),
         .a_val    (op_val),
         .bc_valid (bcast_valid),
         .bc_tag   (bcast_tag),
         .bc_val   (bcast_value),
         .grant    (slot_grant[s]),
         .busy     (slot_busy[s]),
         .ready    (slot_ready[s]),
         .o_op     (s_op[s]),
         .o_imm    (s_imm[s]),
         .o_vj     (s_vj[s]),
         .o_vk     (s_vk[s])
      );
   end

   assign disp_valid = rdy_any;
   assign disp_tag   = rdy_idx;
   assign disp_op    = s_op[rdy_idx];
   assign disp_imm   = s_imm[rdy_idx];
   assign disp_vj    = s_vj[rdy_idx];
   assign disp_vk    = s_vk[rdy_idx];

   assign peek_value   = rd_val[2];
   assign peek_pending = rd_pend[2];
   assign peek_tag     = rd_tag[2];

endmodule

// File: rtl/rs_rename_core_chk.sv
module rs_rename_core_chk #(
   parameter int NUM_RS = 4,
   localparam int TAG_W = $clog2(NUM_RS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic              issue_ready,
   input logic [TAG_W-1:0]  issue_tag,
   input logic              bcast_valid,
   input logic [TAG_W-1:0]  bcast_tag,
   input logic              disp_valid,
   input logic              disp_ready,
   input logic [TAG_W-1:0]  disp_tag,
   input logic [NUM_RS-1:0] slot_busy,
   input logic [NUM_RS-1:0] slot_ready,
   input logic [NUM_RS-1:0] slot_grant
);

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_grant)); // R7

   AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_grant != '0) |-> (((slot_grant - NUM_RS'(1)) & slot_ready) == '0)); // R7

   AST_GRANT_HAS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_grant & ~slot_ready) == '0)); // R6

   AST_NOT_REOFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready) |=> !slot_ready[$past(disp_tag)]); // R7

   AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_ready |-> (&slot_busy)); // R2

   AST_ISSUE_ALLOCATES: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |=> slot_busy[$past(issue_tag)]); // R2

   AST_BCAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |=> !slot_busy[$past(bcast_tag)]); // R8

endmodule

bind rs_rename_core rs_rename_core_chk #(.NUM_RS(NUM_RS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .issue_tag   (issue_tag),
   .bcast_valid (bcast_valid),
   .bcast_tag   (bcast_tag),
   .disp_valid  (disp_valid),
   .disp_ready  (disp_ready),
   .disp_tag    (disp_tag),
   .slot_busy   (slot_busy),
   .slot_ready  (slot_ready),
   .slot_grant  (slot_grant)
);

// File: tb/rs_rename_core_tb_top.sv
module rs_rename_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid;
   logic [3:0]  issue_op;
   logic [2:0]  issue_src_a, issue_src_b, issue_dst;
   logic [7:0]  issue_imm;
   logic        issue_ready;
   logic [1:0]  issue_tag;
   logic        bcast_valid;
   logic [1:0]  bcast_tag;
   logic [15:0] bcast_value;
   logic        disp_ready;
   logic        disp_valid;
   logic [1:0]  disp_tag;
   logic [3:0]  disp_op;
   logic [15:0] disp_vj, disp_vk;
   logic [7:0]  disp_imm;
   logic [2:0]  peek_reg;
   logic [15:0] peek_value;
   logic        peek_pending;
   logic [1:0]  peek_tag;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   rs_rename_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_op(issue_op),
      .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
      .issue_dst(issue_dst), .issue_imm(issue_imm),
      .issue_ready(issue_ready), .issue_tag(issue_tag),
      .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value),
      .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_tag(disp_tag),
      .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_imm(disp_imm),
      .peek_reg(peek_reg), .peek_value(peek_value),
      .peek_pending(peek_pending), .peek_tag(peek_tag)
   );

   typedef struct packed {
      logic        iv;
      logic [3:0]  op;
      logic [2:0]  s1;
      logic [2:0]  s2;
      logic [2:0]  dst;
      logic [7:0]  imm;
      logic        cv;
      logic [1:0]  ctag;
      logic [15:0] cval;
      logic        dr;
      logic [2:0]  pa;
      logic        e_ir;
      logic [1:0]  e_itag;
      logic        e_dv;
      logic [1:0]  e_dtag;
      logic [3:0]  e_op;
      logic [15:0] e_vj;
      logic [15:0] e_vk;
      logic [7:0]  e_imm;
      logic [15:0] e_pv;
      logic        e_pp;
      logic [1:0]  e_pt;
   } vec_t;

   localparam int NV = 19;

   // Each row is one cycle: stimulus, then outputs expected before that edge.
   localparam vec_t VECS [NV] = '{
      // 0 R1 R2: reset state; A: op1 r1,r2 -> r3 to station 0
      '{1,1,1,2,3,5,       0,0,0,        0,3, 1,0, 0,0,0,0,0,0,                0,0,0},
      // 1 R3 R4 R10: B reads r3 twice (tag 0); A offered, disp_ready low
      '{1,2,3,3,4,6,       0,0,0,        0,3, 1,1, 1,0,1,0,0,5,                0,1,0},
      // 2 R7 R10: C renames r3 to tag 2; A still offered, now taken
      '{1,3,4,1,3,7,       0,0,0,        1,3, 1,2, 1,0,1,0,0,5,                0,1,0},
      // 3 R5 R9: A broadcasts; r3 now owned by tag 2 so no write
      '{0,0,0,0,0,0,       1,0,'h1111,   1,3, 1,3, 0,0,0,0,0,0,                0,1,2},
      // 4 R5 R8 R9: B has both operands; station 0 free again; r3 unchanged
      '{0,0,0,0,0,0,       0,0,0,        0,3, 1,0, 1,1,2,'h1111,'h1111,6,      0,1,2},
      // 5 R2 R8: D reuses station 0; reads r3 (tag 2) and r5 (value)
      '{1,4,3,5,5,8,       0,0,0,        1,5, 1,0, 1,1,2,'h1111,'h1111,6,      0,0,0},
      // 6 R11: E issues while its source producer (tag 1) broadcasts
      '{1,5,4,4,6,9,       1,1,'h2222,   0,4, 1,3, 0,0,0,0,0,0,                0,1,1},
      // 7 R7 R9: C and E ready, lowest (2) offered; r4 written
      '{0,0,0,0,0,0,       0,0,0,        1,4, 1,1, 1,2,3,'h2222,0,7,           'h2222,0,0},
      // 8 R11: E carries forwarded values
      '{0,0,0,0,0,0,       0,0,0,        1,6, 1,1, 1,3,5,'h2222,'h2222,9,      0,1,3},
      // 9 R12: C retires r3 while F claims r3
      '{1,6,0,0,3,10,      1,2,'h3333,   0,3, 1,1, 0,0,0,0,0,0,                0,1,2},
      // 10 R12 R5: r3 written and owned by tag 1; D woke up
      '{0,0,0,0,0,0,       0,0,0,        1,3, 1,2, 1,0,4,'h3333,0,8,           'h3333,1,1},
      // 11 R4 R6: G waits on tags 1 and 3; F offered
      '{1,7,3,6,7,11,      0,0,0,        1,7, 1,2, 1,1,6,0,0,10,               0,0,0},
      // 12 R2: all stations allocated, issue of H to r0 refused
      '{1,8,0,0,0,12,      0,0,0,        0,0, 0,0, 0,0,0,0,0,0,                0,0,0},
      // 13 R2: r0 untouched by refused issue; E broadcasts
      '{0,0,0,0,0,0,       1,3,'h4444,   0,0, 0,0, 0,0,0,0,0,0,                0,0,0},
      // 14 R11 R6: I forwards tag 1 result; G still missing one operand
      '{1,9,6,3,2,13,      1,1,'h5555,   0,6, 1,3, 0,0,0,0,0,0,                'h4444,0,0},
      // 15 R5 R7: G ready with two snooped values
      '{0,0,0,0,0,0,       0,0,0,        1,3, 1,1, 1,2,7,'h5555,'h4444,11,     'h5555,0,0},
      // 16 R6: I offered
      '{0,0,0,0,0,0,       0,0,0,        1,2, 1,1, 1,3,9,'h4444,'h5555,13,     0,1,3},
      // 17 R9: D retires r5
      '{0,0,0,0,0,0,       1,0,'h6666,   0,5, 1,1, 0,0,0,0,0,0,                0,1,0},
      // 18 R9 R8: r5 written, station 0 free
      '{0,0,0,0,0,0,       0,0,0,        0,5, 1,0, 0,0,0,0,0,0,                'h6666,0,0}
   };

   task automatic chk(input string req, input string what, input int vec,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s vec %0d %s: actual %0h expected %0h", req, vec, what, act, exp);
      end
   endtask

   task automatic drive_idle();
      issue_valid = 1'b0; issue_op = '0; issue_src_a = '0; issue_src_b = '0;
      issue_dst = '0; issue_imm = '0; bcast_valid = 1'b0; bcast_tag = '0;
      bcast_value = '0; disp_ready = 1'b0; peek_reg = '0;
   endtask

   initial begin
      drive_idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         issue_valid = VECS[i].iv;  issue_op = VECS[i].op;
         issue_src_a = VECS[i].s1;  issue_src_b = VECS[i].s2;
         issue_dst   = VECS[i].dst; issue_imm = VECS[i].imm;
         bcast_valid = VECS[i].cv;  bcast_tag = VECS[i].ctag;
         bcast_value = VECS[i].cval;
         disp_ready  = VECS[i].dr;  peek_reg = VECS[i].pa;
         #1;
         chk("R2", "issue_ready", i, 32'(issue_ready), 32'(VECS[i].e_ir));
         if (VECS[i].e_ir)
            chk("R2", "issue_tag", i, 32'(issue_tag), 32'(VECS[i].e_itag));
         chk("R6", "disp_valid", i, 32'(disp_valid), 32'(VECS[i].e_dv));
         if (VECS[i].e_dv) begin
            chk("R7", "disp_tag", i, 32'(disp_tag), 32'(VECS[i].e_dtag));
            chk("R6", "disp_op",  i, 32'(disp_op),  32'(VECS[i].e_op));
            chk("R5", "disp_vj",  i, 32'(disp_vj),  32'(VECS[i].e_vj));
            chk("R5", "disp_vk",  i, 32'(disp_vk),  32'(VECS[i].e_vk));
            chk("R6", "disp_imm", i, 32'(disp_imm), 32'(VECS[i].e_imm));
         end
         chk("R9", "peek_value",   i, 32'(peek_value),   32'(VECS[i].e_pv));
         chk("R10", "peek_pending", i, 32'(peek_pending), 32'(VECS[i].e_pp));
         if (VECS[i].e_pp)
            chk("R10", "peek_tag", i, 32'(peek_tag), 32'(VECS[i].e_pt));
      end

      // R1: reset in mid-run, stations 2 and 3 still allocated, r5 holds 6666
      @(negedge clk);
      drive_idle();
      peek_reg = 3'd5;
      rst_n = 1'b0;
      #1;
      chk("R1", "issue_ready after reset", 100, 32'(issue_ready), 32'd1);
      chk("R1", "issue_tag after reset",   100, 32'(issue_tag),   32'd0);
      chk("R1", "disp_valid after reset",  100, 32'(disp_valid),  32'd0);
      chk("R1", "r5 value after reset",    100, 32'(peek_value),  32'd0);
      chk("R1", "r5 pending after reset",  100, 32'(peek_pending), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R3: first issue after reset sees register values as present
      issue_valid = 1'b1; issue_op = 4'hA; issue_src_a = 3'd5; issue_src_b = 3'd6;
      issue_dst = 3'd1; issue_imm = 8'h55;
      @(negedge clk);
      drive_idle();
      #1;
      chk("R3", "disp_valid fresh issue", 101, 32'(disp_valid), 32'd1);
      chk("R3", "disp_vj fresh issue",    101, 32'(disp_vj),    32'd0);
      chk("R6", "disp_imm fresh issue",   101, 32'(disp_imm),   32'h55);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule